// File: doc/BRIEF.md
# Host Mailbox Parallel Interface

This block is an 8-bit parallel slave port that sits between a host microcontroller and an embedded processor. The host reaches it through four addresses, using an active-low chip select with active-low read and write strobes. Address 00b is a control register that the host writes and reads directly. It never involves the processor and never produces a response. Address 01b is a read-only status byte for hosts that poll. Addresses 10b and 11b form the mailbox: the host writes a control byte at 10b and then a data byte at 11b, and the write of the data byte is what delivers the command to the processor.

The processor answers by posting a control/data pair. The block then pulls the active-low host interrupt low. The host reads the control byte at 10b first and the data byte at 11b second. The end of the data-byte read releases the outbound slot, which raises the interrupt again and tells the processor that it may post again. The processor can also post an unsolicited response, which is marked in bit 7 of the outbound control byte. Bit 7 is reserved in host commands, and bit 6 of the command control byte selects word (1) or byte (0) transfer.

The host strobes are asynchronous. Each one passes through a two-flop synchronizer, and the block acts on the release edge of the strobe. Address and write data must therefore stay valid for three clocks after the strobe is released.

Top module: `hmb_port`

## Requirements
- R1: After reset the block is in this state: host_irq_n=1, rsp_room=1, mb_new=0, ctl_reg=0x00, and the status byte reads 0x00.
- R2: A write to address 00b stores the byte in ctl_reg, and a read of 00b returns it. Such a write never sets mb_new and never lowers host_irq_n.
- R3: A write to address 10b alone leaves mb_new low. A following write to address 11b sets mb_new and presents the control byte on mb_ctrl and the data byte on mb_data. This happens within three clocks of the write strobe being released.
- R4: mb_word equals bit 6 of the delivered mailbox control byte (1 = word transfer, 0 = byte transfer).
- R5: A one-clock pulse on mb_take clears mb_new.
- R6: If the host writes address 11b while mb_new is set, the delivered mail is kept unchanged and a sticky overrun bit (status bit 2) is set. Any host write to address 01b clears that bit.
- R7: A rsp_post pulse while rsp_room=1 lowers host_irq_n and rsp_room on the next clock. A rsp_post pulse while rsp_room=0 is ignored.
- R8: While a response is pending, a read of 10b returns the outbound control byte and a read of 11b returns the outbound data byte. The end of a 10b read leaves host_irq_n low. The end of a 11b read sets host_irq_n and rsp_room to 1.
- R9: The status byte at address 01b reads bit 0 = response pending, bit 1 = mail unread (mb_new), bit 2 = overrun. Bits 7..3 read 0.
- R10: Bit 7 of the outbound control byte equals rsp_unsol captured at the post, and bits 6..0 equal rsp_ctrl.
- R11: Read and write strobes have no effect while host_cs_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-side clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the addressed register |
| host_irq_n | output | 1 | Response-waiting interrupt to the host, active low |
| ctl_reg | output | 8 | Directly mapped control register |
| mb_new | output | 1 | New mail is waiting for the processor |
| mb_ctrl | output | 8 | Delivered mailbox control byte |
| mb_data | output | 8 | Delivered mailbox data byte |
| mb_word | output | 1 | Word-transfer select of the delivered command |
| mb_take | input | 1 | Processor acknowledges the mail (one-clock pulse) |
| rsp_post | input | 1 | Processor posts a response (one-clock pulse) |
| rsp_unsol | input | 1 | The posted response is unsolicited |
| rsp_ctrl | input | 7 | Response control bits 6..0 |
| rsp_data | input | 8 | Response data byte |
| rsp_room | output | 1 | The outbound slot is free for a post |

## Verification
A host write takes effect on the third clock edge after the strobe is released: two synchronizer stages, then the register update. The bench therefore holds address and data for four clocks after release and samples state only after that. Read data is combinational from the address and the held state, so it is sampled while the strobe is still low. The release effect of a 11b read follows the same three-edge rule as a write. A processor post or take acts at the next clock edge, and the bench samples on the falling edge that follows.

// File: rtl/hmb_port.sv
module hmb_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_cs_n,
  input  logic       host_rd_n,
  input  logic       host_wr_n,
  input  logic [1:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       host_irq_n,
  output logic [7:0] ctl_reg,
  output logic       mb_new,
  output logic [7:0] mb_ctrl,
  output logic [7:0] mb_data,
  output logic       mb_word,
  input  logic       mb_take,
  input  logic       rsp_post,
  input  logic       rsp_unsol,
  input  logic [6:0] rsp_ctrl,
  input  logic [7:0] rsp_data
  ,output logic      rsp_room
);

  logic [2:0] wr_s, rd_s;
  logic       wr_evt, rd_evt;
  logic [7:0] cmd_hold;
  logic       ovr;
  logic       rsp_full;
  logic [7:0] out_ctrl, out_data;
  logic [7:0] status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_s <= '0;
      rd_s <= '0;
    end else begin
      wr_s <= {wr_s[1:0], ~host_cs_n & ~host_wr_n};
      rd_s <= {rd_s[1:0], ~host_cs_n & ~host_rd_n};
    end
  end

  assign wr_evt = wr_s[2] & ~wr_s[1];
  assign rd_evt = rd_s[2] & ~rd_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_reg  <= '0;
      cmd_hold <= '0;
      mb_ctrl  <= '0;
      mb_data  <= '0;
      mb_new   <= 1'b0;
      ovr      <= 1'b0;
    end else begin
      if (mb_take) mb_new <= 1'b0;
      if (wr_evt) begin
        case (host_addr)
          2'b00: ctl_reg <= host_wdata;
          2'b01: ovr <= 1'b0;
          2'b10: cmd_hold <= host_wdata;
          default: begin
            if (mb_new && !mb_take) begin
              ovr <= 1'b1;
            end else begin
              mb_ctrl <= cmd_hold;
              mb_data <= host_wdata;
              mb_new  <= 1'b1;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_full <= 1'b0;
      out_ctrl <= '0;
      out_data <= '0;
    end else if (rsp_full) begin
      if (rd_evt && host_addr == 2'b11) rsp_full <= 1'b0;
    end else if (rsp_post) begin
      rsp_full <= 1'b1;
      out_ctrl <= {rsp_unsol, rsp_ctrl};
      out_data <= rsp_data;
    end
  end

  assign mb_word    = mb_ctrl[6];
  assign host_irq_n = ~rsp_full;
  assign rsp_room   = ~rsp_full;
  assign status     = {5'b0, ovr, mb_new, rsp_full};

  always_comb begin
    case (host_addr)
      2'b00:   host_rdata = ctl_reg;
      2'b01:   host_rdata = status;
      2'b10:   host_rdata = out_ctrl;
      default: host_rdata = out_data;
    endcase
  end

  // R7
  post_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_post && rsp_room) |=> !host_irq_n);

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && host_addr == 2'b11 && !host_irq_n) |=> (host_irq_n && rsp_room));

  // R3
  new_mail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mb_new) |-> $past(wr_evt && host_addr == 2'b11));

  // R6
  mail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_new && !mb_take) |=> ($stable(mb_data) && $stable(mb_ctrl)));

  // R6
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !(wr_evt && host_addr == 2'b01)) |=> ovr);

  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_room && !rd_evt) |=> ($stable(out_data) && !rsp_room));

endmodule

// File: tb/hmb_port_tb.sv
module hmb_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       host_irq_n, mb_new, mb_word, rsp_room;
  logic [7:0] ctl_reg, mb_ctrl, mb_data;
  logic       mb_take = 1'b0, rsp_post = 1'b0, rsp_unsol = 1'b0;
  logic [6:0] rsp_ctrl = '0;
  logic [7:0] rsp_data = '0;

  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hmb_port u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d, input bit sel = 1);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_cs_n = ~sel; host_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    host_cs_n = 1'b1; host_wr_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic hread(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_cs_n = 1'b0; host_rd_n = 1'b0;
    repeat (3) @(negedge clk);
    d = host_rdata;
    host_cs_n = 1'b1; host_rd_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic post(input bit u, input logic [6:0] c, input logic [7:0] d);
    @(negedge clk);
    rsp_unsol = u; rsp_ctrl = c; rsp_data = d; rsp_post = 1'b1;
    @(negedge clk);
    rsp_post = 1'b0;
  endtask

  task automatic take();
    @(negedge clk);
    mb_take = 1'b1;
    @(negedge clk);
    mb_take = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(host_irq_n && rsp_room && !mb_new && ctl_reg == 0, "R1 outputs", {host_irq_n, rsp_room, mb_new}, 3'b110);
    hread(2'b01, r);
    chk(r == 8'h00, "R1 status", r, 0);

    // R2: full sweep of the direct register
    for (int i = 0; i < 256; i++) begin
      hwrite(2'b00, 8'(i));
      hread(2'b00, r);
      chk(r == 8'(i) && ctl_reg == 8'(i), "R2 readback", r, i);
      chk(host_irq_n && !mb_new, "R2 no response", {host_irq_n, mb_new}, 2'b10);
    end

    // R11: write with chip select high ignored
    hwrite(2'b00, 8'h5A, 0);
    chk(ctl_reg == 8'hFF, "R11 deselected write", ctl_reg, 8'hFF);

    // R3 R4 R5 R9 mailbox sweep
    for (int i = 0; i < 32; i++) begin
      logic [7:0] c, d;
      c = 8'((i * 37) + 3);
      d = 8'(~c ^ 8'(i));
      hwrite(2'b10, c);
      chk(!mb_new, "R3 control alone", mb_new, 0);
      hwrite(2'b11, d);
      chk(mb_new && mb_ctrl == c && mb_data == d, "R3 delivered", {mb_ctrl, mb_data}, {c, d});
      chk(mb_word == c[6], "R4 word select", mb_word, c[6]);
      hread(2'b01, r);
      chk(r == 8'h02, "R9 mail pending", r, 2);
      take();
      chk(!mb_new, "R5 take clears", mb_new, 0);
    end

    // R6 overrun
    hwrite(2'b10, 8'h11); hwrite(2'b11, 8'h22);
    hwrite(2'b10, 8'h33); hwrite(2'b11, 8'h44);
    chk(mb_ctrl == 8'h11 && mb_data == 8'h22, "R6 mail kept", {mb_ctrl, mb_data}, 16'h1122);
    hread(2'b01, r);
    chk(r == 8'h06, "R6 overrun set", r, 6);
    take();
    hread(2'b01, r);
    chk(r == 8'h04, "R6 overrun sticky", r, 4);
    hwrite(2'b01, 8'h00);
    hread(2'b01, r);
    chk(r == 8'h00, "R6 overrun cleared", r, 0);

    // R7 R8 R10 response sweep
    for (int i = 0; i < 16; i++) begin
      logic [6:0] c;
      logic [7:0] d;
      bit u;
      u = i[0];
      c = 7'(i * 9);
      d = 8'(i * 17 + 1);
      post(u, c, d);
      chk(!host_irq_n && !rsp_room, "R7 post raises irq", {host_irq_n, rsp_room}, 0);
      post(~u, ~c, ~d);
      hread(2'b01, r);
      chk(r == 8'h01, "R9 response pending", r, 1);
      hread(2'b10, r);
      chk(r == {u, c}, "R10 control byte", r, {u, c});
      chk(!host_irq_n, "R8 irq held after control read", host_irq_n, 0);
      hread(2'b11, r);
      chk(r == d, "R7 ignored post / R8 data", r, d);
      chk(host_irq_n && rsp_room, "R8 release", {host_irq_n, rsp_room}, 2'b11);
    end

    // R11: deselected read does not release
    post(1'b0, 7'h15, 8'hA5);
    @(negedge clk);
    host_addr = 2'b11; host_rd_n = 1'b0;
    repeat (3) @(negedge clk);
    host_rd_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!host_irq_n, "R11 deselected read", host_irq_n, 0);
    hread(2'b11, r);
    chk(host_irq_n && r == 8'hA5, "R8 final release", r, 8'hA5);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule